// File: doc/BRIEF.md
# Ingress Frame Length and Storm Class Filter

This block sits on the receive side of one switch port and watches a byte-wide frame stream. A qualifier marks each accepted byte, a start flag marks the first byte and an end flag marks the last. While a frame goes by, the block counts its bytes, looks for an 802.1Q tag and inspects the destination address. On the cycle after the last byte it reports four things. The first is a drop verdict, given when the frame is longer than the permitted size. The second is a storm-class flag for a separate rate limiter. The third is the tag flag, and the fourth is the measured length.

The permitted size comes from two mode inputs, checked in priority order, and from whether the frame is tagged. The storm class covers broadcast frames only, or broadcast and multicast frames, depending on one mode input. All three mode inputs are captured with the first byte of a frame and hold for the rest of that frame.

Top module: `frame_len_filter`

## Requirements
- R1: `resLen` reports the number of accepted bytes (cycles with `inValid` high), from the start byte through the end byte inclusive. Idle cycles inside a frame do not count.
- R2: `resValid` is high for exactly one cycle, the cycle after the end byte is accepted. `resDrop`, `resStorm` and `resTagged` are low whenever `resValid` is low.
- R3: A frame is tagged when its bytes at 0-based positions 12 and 13 are 0x81 and 0x00. A frame shorter than 14 bytes is never tagged.
- R4: With `cfgHugeEn` high, the limit is 1916 bytes, whatever the value of `cfgLegalOff`.
- R5: With `cfgHugeEn` low and `cfgLegalOff` high, the limit is 1536 bytes for both tagged and untagged frames.
- R6: With both mode inputs low, the limit is 1522 bytes for tagged frames and 1518 bytes for untagged frames. `resDrop` is high exactly when the length exceeds the selected limit.
- R7: The length counter saturates at 2^LEN_W-1 and does not wrap. A longer frame reports that maximum and is dropped.
- R8: A destination address of six 0xFF bytes sets `resStorm` in both storm modes.
- R9: A destination address whose first byte has bit 0 set (address bit 40, the group bit) sets `resStorm` only when `cfgBcastOnly` is low. Frames shorter than 6 bytes never set `resStorm`.
- R10: The mode inputs are sampled with the start byte. Changing them later in the frame does not alter that frame's result.
- R11: During and right after reset, `resValid`, `resDrop`, `resStorm`, `resTagged` and `resLen` are zero.
- R12: Bytes that arrive outside a frame without a start flag are ignored and produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Frame byte |
| inValid | input | 1 | Byte qualifier |
| inSof | input | 1 | First byte of a frame |
| inEof | input | 1 | Last byte of a frame |
| cfgHugeEn | input | 1 | Selects the large-frame limit (highest priority) |
| cfgLegalOff | input | 1 | Relaxes the standard limits to one common limit |
| cfgBcastOnly | input | 1 | Storm class covers all-ones addresses only |
| resValid | output | 1 | Result strobe |
| resDrop | output | 1 | Frame exceeds the limit |
| resStorm | output | 1 | Frame is in the storm class |
| resTagged | output | 1 | Frame carries a VLAN tag |
| resLen | output | LEN_W | Measured length (saturating) |

## Verification
The bench builds the block with LEN_W set to 11, so the counter saturates at 2047 bytes. A frame of about 2100 bytes then exercises saturation in a few thousand cycles, while every limit still fits in the counter. The limit parameters keep their defaults, so each limit is tested one byte inside and one byte outside its boundary. Idle gaps, mode changes in the middle of a frame, stray bytes and single-byte frames test how the position tracker and the capture of mode inputs handle framing.

// File: rtl/flf_pkg.sv
package flf_pkg;

  typedef struct packed {
    logic start;   // accepted byte carries the start flag
    logic beat;    // accepted byte belongs to a frame
    logic daByte;  // byte lies in the destination address
    logic tpidHi;  // byte is at the upper type/tag position
    logic tpidLo;  // byte is at the lower type/tag position
    logic finish;  // accepted byte closes the frame
  } flfStrobe_t;

  localparam int DA_BYTES  = 6;
  localparam int TPID_POS  = 12;
  localparam int POS_W     = 4;

endpackage

// File: rtl/flf_ctrl.sv
module flf_ctrl
  import flf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inSof,
  input  logic       inEof,
  output flfStrobe_t stb
);

  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_DA  = POS_W'(DA_BYTES);
  localparam logic [POS_W-1:0] POS_HI  = POS_W'(TPID_POS);
  localparam logic [POS_W-1:0] POS_LO  = POS_W'(TPID_POS + 1);

  logic             inFrame;
  logic [POS_W-1:0] nextPos;
  logic [POS_W-1:0] pos;
  logic             beat;

  always_comb begin
    pos        = inSof ? '0 : nextPos;
    beat       = inValid && (inSof || inFrame);
    stb.start  = inValid && inSof;
    stb.beat   = beat;
    stb.daByte = beat && (pos < POS_DA);
    stb.tpidHi = beat && (pos == POS_HI);
    stb.tpidLo = beat && (pos == POS_LO);
    stb.finish = beat && inEof;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      nextPos <= '0;
    end else if (beat) begin
      inFrame <= !inEof;
      nextPos <= (pos == POS_MAX) ? POS_MAX : pos + 1'b1;
    end
  end

endmodule

// File: rtl/flf_datapath.sv
module flf_datapath
  import flf_pkg::*;
#(
  parameter int LEN_W     = 12,
  parameter int HUGE_MAX  = 1916,
  parameter int LEGAL_MAX = 1536,
  parameter int TAG_MAX   = 1522,
  parameter int UNTAG_MAX = 1518,
  parameter logic [15:0] TPID = 16'h8100
) (
  input  logic             clk,
  input  logic             rstN,
  input  flfStrobe_t       stb,
  input  logic [7:0]       inData,
  input  logic             cfgHugeEn,
  input  logic             cfgLegalOff,
  input  logic             cfgBcastOnly,
  output logic             resValid,
  output logic             resDrop,
  output logic             resStorm,
  output logic             resTagged,
  output logic [LEN_W-1:0] resLen
);

  localparam logic [LEN_W-1:0] LEN_SAT   = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] LIM_HUGE  = LEN_W'(HUGE_MAX);
  localparam logic [LEN_W-1:0] LIM_LEGAL = LEN_W'(LEGAL_MAX);
  localparam logic [LEN_W-1:0] LIM_TAG   = LEN_W'(TAG_MAX);
  localparam logic [LEN_W-1:0] LIM_UNTAG = LEN_W'(UNTAG_MAX);
  localparam logic [LEN_W-1:0] LEN_DA    = LEN_W'(DA_BYTES);

  logic [LEN_W-1:0] lenCnt, lenNow;
  logic allOnesR, allOnesNow;
  logic grpR, grpNow;
  logic hiR, hiNow;
  logic tagR, tagNow;
  logic hugeR, legalR, bcOnlyR;
  logic hugeEff, legalEff, bcOnlyEff;
  logic isFF;
  logic [LEN_W-1:0] limit;
  logic dropNow, stormNow;

  always_comb begin
    hugeEff   = stb.start ? cfgHugeEn    : hugeR;
    legalEff  = stb.start ? cfgLegalOff  : legalR;
    bcOnlyEff = stb.start ? cfgBcastOnly : bcOnlyR;
    isFF      = (inData == 8'hFF);

    if (stb.start)             lenNow = LEN_W'(1);
    else if (lenCnt == LEN_SAT) lenNow = LEN_SAT;
    else                       lenNow = lenCnt + 1'b1;

    allOnesNow = stb.start ? isFF : (allOnesR && (!stb.daByte || isFF));
    grpNow     = stb.start ? inData[0] : grpR;
    hiNow      = stb.start ? 1'b0 : (stb.tpidHi ? (inData == TPID[15:8]) : hiR);
    tagNow     = stb.start ? 1'b0
               : (tagR || (stb.tpidLo && hiR && (inData == TPID[7:0])));

    if (hugeEff)       limit = LIM_HUGE;
    else if (legalEff) limit = LIM_LEGAL;
    else if (tagNow)   limit = LIM_TAG;
    else               limit = LIM_UNTAG;

    dropNow  = lenNow > limit;
    stormNow = (lenNow >= LEN_DA) && (allOnesNow || (!bcOnlyEff && grpNow));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenCnt   <= '0;
      allOnesR <= 1'b0;
      grpR     <= 1'b0;
      hiR      <= 1'b0;
      tagR     <= 1'b0;
      hugeR    <= 1'b0;
      legalR   <= 1'b0;
      bcOnlyR  <= 1'b0;
    end else if (stb.beat) begin
      lenCnt   <= lenNow;
      allOnesR <= allOnesNow;
      grpR     <= grpNow;
      hiR      <= hiNow;
      tagR     <= tagNow;
      if (stb.start) begin
        hugeR   <= cfgHugeEn;
        legalR  <= cfgLegalOff;
        bcOnlyR <= cfgBcastOnly;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      resDrop   <= 1'b0;
      resStorm  <= 1'b0;
      resTagged <= 1'b0;
      resLen    <= '0;
    end else begin
      resValid  <= stb.finish;
      resDrop   <= stb.finish && dropNow;
      resStorm  <= stb.finish && stormNow;
      resTagged <= stb.finish && tagNow;
      resLen    <= stb.finish ? lenNow : '0;
    end
  end

endmodule

// File: rtl/frame_len_filter.sv
module frame_len_filter
  import flf_pkg::*;
#(
  parameter int LEN_W     = 12,
  parameter int HUGE_MAX  = 1916,
  parameter int LEGAL_MAX = 1536,
  parameter int TAG_MAX   = 1522,
  parameter int UNTAG_MAX = 1518
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       inData,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inEof,
  input  logic             cfgHugeEn,
  input  logic             cfgLegalOff,
  input  logic             cfgBcastOnly,
  output logic             resValid,
  output logic             resDrop,
  output logic             resStorm,
  output logic             resTagged,
  output logic [LEN_W-1:0] resLen
);

  flfStrobe_t stb;

  flf_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inSof   (inSof),
    .inEof   (inEof),
    .stb     (stb)
  );

  flf_datapath #(
    .LEN_W     (LEN_W),
    .HUGE_MAX  (HUGE_MAX),
    .LEGAL_MAX (LEGAL_MAX),
    .TAG_MAX   (TAG_MAX),
    .UNTAG_MAX (UNTAG_MAX)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .inData       (inData),
    .cfgHugeEn    (cfgHugeEn),
    .cfgLegalOff  (cfgLegalOff),
    .cfgBcastOnly (cfgBcastOnly),
    .resValid     (resValid),
    .resDrop      (resDrop),
    .resStorm     (resStorm),
    .resTagged    (resTagged),
    .resLen       (resLen)
  );

endmodule

// File: rtl/flf_checker.sv
module flf_checker #(
  parameter int LEN_W     = 12,
  parameter int HUGE_MAX  = 1916,
  parameter int UNTAG_MAX = 1518
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inEof,
  input logic             resValid,
  input logic             resDrop,
  input logic             resStorm,
  input logic             resTagged,
  input logic [LEN_W-1:0] resLen
);

  AST_RESULT_AFTER_EOF: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(inValid && inEof)); // R2

  AST_FLAGS_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> (!resDrop && !resStorm && !resTagged)); // R2

  AST_HUGE_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resDrop) |-> (int'(resLen) <= HUGE_MAX)); // R4

  AST_UNTAG_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && (int'(resLen) <= UNTAG_MAX)) |-> !resDrop); // R6

  AST_TAG_MIN: assert property (@(posedge clk) disable iff (!rstN)
    resTagged |-> (int'(resLen) >= 14)); // R3

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resLen != '0)); // R7

  AST_SHORT_NO_STORM: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && (int'(resLen) < 6)) |-> !resStorm); // R9

endmodule

bind frame_len_filter flf_checker #(
  .LEN_W     (LEN_W),
  .HUGE_MAX  (HUGE_MAX),
  .UNTAG_MAX (UNTAG_MAX)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inEof     (inEof),
  .resValid  (resValid),
  .resDrop   (resDrop),
  .resStorm  (resStorm),
  .resTagged (resTagged),
  .resLen    (resLen)
);

// File: tb/tb_frame_len_filter.sv
module tb_frame_len_filter;

  localparam int LEN_W = 11;
  localparam int SAT   = (1 << LEN_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic cfgHugeEn = 1'b0, cfgLegalOff = 1'b0, cfgBcastOnly = 1'b0;
  logic resValid, resDrop, resStorm, resTagged;
  logic [LEN_W-1:0] resLen;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  frame_len_filter #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .inSof(inSof), .inEof(inEof), .cfgHugeEn(cfgHugeEn),
    .cfgLegalOff(cfgLegalOff), .cfgBcastOnly(cfgBcastOnly),
    .resValid(resValid), .resDrop(resDrop), .resStorm(resStorm),
    .resTagged(resTagged), .resLen(resLen)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expLimit(input bit h, input bit l, input bit t);
    if (h) return 1916;
    if (l) return 1536;
    return t ? 1522 : 1518;
  endfunction

  // daKind: 0 unicast, 1 all-ones, 2 group address
  function automatic logic [7:0] byteAt(input int i, input int daKind, input bit tag);
    if (i < 6) begin
      if (daKind == 1) return 8'hFF;
      if (daKind == 2) return (i == 0) ? 8'h01 : 8'h5E;
      return 8'h10 + 8'(i);
    end
    if (i < 12) return 8'h20 + 8'(i);
    if (i == 12) return tag ? 8'h81 : 8'h08;
    if (i == 13) return 8'h00;
    return 8'(i);
  endfunction

  task automatic sendFrame(input int len, input int daKind, input bit tag,
                           input bit h, input bit l, input bit bo,
                           input bit gaps, input bit flipMid, input string req);
    int expLen;
    bit expTag, expDrop, expStorm;
    cfgHugeEn = h; cfgLegalOff = l; cfgBcastOnly = bo;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (gaps && (i % 7 == 3)) begin
        inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
        @(negedge clk);
      end
      inValid = 1'b1;
      inSof = (i == 0);
      inEof = (i == len - 1);
      inData = byteAt(i, daKind, tag);
      if (flipMid && i == 1) begin
        cfgHugeEn = !h; cfgLegalOff = !l; cfgBcastOnly = !bo;
      end
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
    expLen   = (len > SAT) ? SAT : len;
    expTag   = tag && (len >= 14);
    expDrop  = expLen > expLimit(h, l, expTag);
    expStorm = (len >= 6) && ((daKind == 1) || (!bo && daKind == 2));
    chk(resValid == 1'b1, "R2", {req, " strobe"}, int'(resValid), 1);
    chk(int'(resLen) == expLen, "R1", {req, " length"}, int'(resLen), expLen);
    chk(resTagged == expTag, "R3", {req, " tag"}, int'(resTagged), int'(expTag));
    chk(resDrop == expDrop, req, "drop", int'(resDrop), int'(expDrop));
    chk(resStorm == expStorm, req, "storm", int'(resStorm), int'(expStorm));
    @(negedge clk);
    chk(resValid == 1'b0, "R2", {req, " one-cycle strobe"}, int'(resValid), 0);
    cfgHugeEn = 1'b0; cfgLegalOff = 1'b0; cfgBcastOnly = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(resValid == 0 && resDrop == 0 && resStorm == 0 && resTagged == 0 && resLen == 0,
        "R11", "outputs in reset", int'(resValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(resValid == 0 && resLen == 0, "R11", "outputs after reset", int'(resLen), 0);
  endtask

  task automatic testDefaultLimits();
    sendFrame(1518, 0, 1'b0, 0, 0, 0, 0, 0, "R6");
    sendFrame(1519, 0, 1'b0, 0, 0, 0, 0, 0, "R6");
    sendFrame(1522, 0, 1'b1, 0, 0, 0, 0, 0, "R6");
    sendFrame(1523, 0, 1'b1, 0, 0, 0, 0, 0, "R6");
  endtask

  task automatic testLegalOff();
    sendFrame(1536, 0, 1'b0, 0, 1, 0, 0, 0, "R5");
    sendFrame(1537, 0, 1'b1, 0, 1, 0, 0, 0, "R5");
  endtask

  task automatic testHuge();
    sendFrame(1916, 0, 1'b0, 1, 1, 0, 0, 0, "R4");
    sendFrame(1917, 0, 1'b1, 1, 0, 0, 0, 0, "R4");
  endtask

  task automatic testSaturate();
    sendFrame(2100, 0, 1'b0, 1, 0, 0, 0, 0, "R7");
  endtask

  task automatic testStorm();
    sendFrame(64, 1, 1'b0, 0, 0, 0, 0, 0, "R8");
    sendFrame(64, 1, 1'b0, 0, 0, 1, 0, 0, "R8");
    sendFrame(64, 2, 1'b0, 0, 0, 0, 0, 0, "R9");
    sendFrame(64, 2, 1'b0, 0, 0, 1, 0, 0, "R9");
    sendFrame(64, 0, 1'b0, 0, 0, 0, 0, 0, "R9");
    sendFrame(4, 1, 1'b0, 0, 0, 0, 0, 0, "R9");
    sendFrame(1, 2, 1'b0, 0, 0, 0, 0, 0, "R9");
  endtask

  task automatic testGaps();
    sendFrame(100, 0, 1'b1, 0, 0, 0, 1, 0, "R1");
    sendFrame(13, 0, 1'b1, 0, 0, 0, 0, 0, "R3");
  endtask

  task automatic testMidChange();
    sendFrame(1530, 0, 1'b0, 0, 0, 0, 0, 1, "R10");
    sendFrame(64, 2, 1'b0, 0, 0, 1, 0, 1, "R10");
  endtask

  task automatic testStray();
    bit seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (resValid) seen = 1'b1;
      inValid = 1'b1; inSof = 1'b0; inEof = (i == 9); inData = 8'hFF;
    end
    @(negedge clk);
    if (resValid) seen = 1'b1;
    inValid = 1'b0; inEof = 1'b0;
    @(negedge clk);
    if (resValid) seen = 1'b1;
    chk(!seen, "R12", "stray bytes produced result", int'(seen), 0);
  endtask

  initial begin
    testReset();
    testDefaultLimits();
    testLegalOff();
    testHuge();
    testSaturate();
    testStorm();
    testGaps();
    testMidChange();
    testStray();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule